// File: doc/BRIEF.md
# Viewport Frame Buffer Address Generator

This block produces the sequence of halfword fetch addresses that a display engine uses to read a frame buffer. The visible picture is a window cut out of a wider virtual screen in memory. Each visible line is a run of consecutive halfwords. Between one line's last visible halfword and the next line's first halfword lies a gap of unused halfwords. A timing generator pulses `frame_start` at the top of every frame and `fetch_adv` once per consumed halfword. The generator walks the window line by line and raises `frame_done` when the whole window has been read.

The fetch address has two parts. The upper part is a fixed bank selector, and the lower part is a 21-bit running halfword pointer, so `fetch_addr` stands for byte-address bits 28 down to 1. Only the lower part advances. A carry out of it is dropped, so a frame never leaves its bank. The window geometry is captured when `frame_start` arrives. The matching end address is derived from that captured copy and is shown on `end_addr`.

Fetched words pass through a combinational reordering stage on the data path. That stage can exchange the two halfwords of a word, exchange the bytes inside each halfword, or do both, which fully reverses the byte order.

Top module: `fb_addr_gen`

## Requirements
- R1: After reset, `fetch_addr`, `end_addr` and `frame_done` are all zero, and the walker is idle until the first `frame_start`.
- R2: A `frame_start` sampled at a clock edge makes `fetch_addr` equal `{cfg_bank, cfg_base}` and clears `frame_done` from the next cycle on.
- R3: A `fetch_adv` that does not complete a line increments the 21-bit pointer by one.
- R4: A `fetch_adv` on the last visible halfword of a line (column `cfg_width-1`) adds `1 + cfg_gap` to the pointer.
- R5: From the cycle after `frame_start`, `end_addr` equals `base + (width + gap) * (lines_m1 + 1)` modulo 2^21, computed from the values captured at that `frame_start`.
- R6: The `fetch_adv` that completes line `cfg_lines_m1` sets `frame_done`. While `frame_done` is 1, the pointer equals `end_addr`.
- R7: A `fetch_adv` has no effect while `frame_done` is 1 or before the first `frame_start` after reset.
- R8: The pointer wraps modulo 2^21. The bank bits (`fetch_addr[27:21]`) change only at `frame_start`.
- R9: Changes to the `cfg_*` inputs during a frame have no effect on the address walk or on `end_addr` until the next `frame_start`.
- R10: When `frame_start` and `fetch_adv` are both 1 in the same cycle, the reload wins and the pointer equals `cfg_base`, not `cfg_base+1`.
- R11: The data path works on 32-bit words. Halfword exchange swaps bits [31:16] with [15:0]. Byte exchange swaps bits [15:8] with [7:0] and bits [31:24] with [23:16]. With both enabled the four bytes come out reversed, and with neither enabled the word passes through unchanged. The path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bank | input | 7 | Fixed bank bits, address bits 28..22 |
| cfg_base | input | 21 | Halfword start pointer, address bits 21..1 |
| cfg_width | input | 11 | Visible halfwords per line (must be at least 1) |
| cfg_gap | input | 11 | Halfwords skipped between visible lines |
| cfg_lines_m1 | input | 10 | Number of visible lines minus one |
| frame_start | input | 1 | Reload pulse at the top of a frame |
| fetch_adv | input | 1 | One halfword consumed |
| swap_half | input | 1 | Exchange the halfwords of each word |
| swap_byte | input | 1 | Exchange the bytes within each halfword |
| fetch_data_in | input | 32 | Word read from memory |
| fetch_data_out | output | 32 | Reordered word |
| fetch_addr | output | 28 | Current fetch address `{bank, pointer}` |
| end_addr | output | 21 | Computed end-of-frame pointer |
| frame_done | output | 1 | Window fully fetched |

## Verification
The cycle assertions guard these properties of the address walk:
- reload on a frame pulse;
- single-step growth inside a line;
- a frozen pointer once the frame is done;
- agreement between the done pointer and the separately computed end value;
- bank bits that never move outside a reload.

Only the bench scenarios can show the rest:
- the inter-line skip across real geometries;
- wraparound of the 21-bit pointer;
- the isolation from configuration changes made mid-frame;
- the reload priority;
- every byte ordering of the data path.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
    localparam int unsigned BANK_W_DEF = 7;
    localparam int unsigned PTR_W_DEF  = 21;
    localparam int unsigned SPAN_W_DEF = 11;
    localparam int unsigned LINE_W_DEF = 10;
    localparam int unsigned DATA_W_DEF = 32;
    localparam int unsigned HWORD_W    = 16;
    localparam int unsigned BYTE_W     = 8;
endpackage

// File: rtl/fbag_endcalc.sv
module fbag_endcalc
    import fbag_pkg::*;
#(
    parameter int unsigned PTR_W  = PTR_W_DEF,
    parameter int unsigned SPAN_W = SPAN_W_DEF,
    parameter int unsigned LINE_W = LINE_W_DEF
) (
    input  logic [PTR_W-1:0]  base,
    input  logic [SPAN_W-1:0] width,
    input  logic [SPAN_W-1:0] gap,
    input  logic [LINE_W-1:0] lines_m1,
    output logic [PTR_W-1:0]  end_ptr
);
    localparam int unsigned STRIDE_W = SPAN_W + 1;
    localparam int unsigned COUNT_W  = LINE_W + 1;
    localparam int unsigned PROD_W   = STRIDE_W + COUNT_W;

    logic [STRIDE_W-1:0] stride;
    logic [COUNT_W-1:0]  count;
    logic [PROD_W-1:0]   span_total;

    always_comb begin
        stride     = STRIDE_W'(width) + STRIDE_W'(gap);
        count      = COUNT_W'(lines_m1) + COUNT_W'(1);
        span_total = PROD_W'(stride) * PROD_W'(count);
        end_ptr    = base + PTR_W'(span_total);
    end
endmodule

// File: rtl/fbag_walker.sv
module fbag_walker
    import fbag_pkg::*;
#(
    parameter int unsigned BANK_W = BANK_W_DEF,
    parameter int unsigned PTR_W  = PTR_W_DEF,
    parameter int unsigned SPAN_W = SPAN_W_DEF,
    parameter int unsigned LINE_W = LINE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              fetch_adv,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [PTR_W-1:0]  cfg_base,
    input  logic [SPAN_W-1:0] cfg_width,
    input  logic [SPAN_W-1:0] cfg_gap,
    input  logic [LINE_W-1:0] cfg_lines_m1,
    input  logic [PTR_W-1:0]  end_ptr,
    output logic [BANK_W-1:0] bank_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [PTR_W-1:0]  base_o,
    output logic [SPAN_W-1:0] width_o,
    output logic [SPAN_W-1:0] gap_o,
    output logic [LINE_W-1:0] lines_o,
    output logic              done_o
);
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [PTR_W-1:0]  base;
        logic [SPAN_W-1:0] width;
        logic [SPAN_W-1:0] gap;
        logic [LINE_W-1:0] lines;
        logic [PTR_W-1:0]  ptr;
        logic [SPAN_W-1:0] col;
        logic [LINE_W-1:0] row;
        logic              active;
        logic              done;
    } walk_t;

    walk_t st_d, st_q;
    logic  line_end, step_ok;

    always_comb begin
        st_d     = st_q;
        line_end = (st_q.col == st_q.width - SPAN_W'(1));
        step_ok  = fetch_adv && st_q.active && !st_q.done;
        if (frame_start) begin
            st_d.bank   = cfg_bank;
            st_d.base   = cfg_base;
            st_d.width  = cfg_width;
            st_d.gap    = cfg_gap;
            st_d.lines  = cfg_lines_m1;
            st_d.ptr    = cfg_base;
            st_d.col    = '0;
            st_d.row    = '0;
            st_d.active = 1'b1;
            st_d.done   = 1'b0;
        end else if (step_ok) begin
            if (line_end) begin
                st_d.col = '0;
                st_d.ptr = st_q.ptr + PTR_W'(st_q.gap) + PTR_W'(1);
                if (st_q.row == st_q.lines) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.row = st_q.row + LINE_W'(1);
                end
            end else begin
                st_d.col = st_q.col + SPAN_W'(1);
                st_d.ptr = st_q.ptr + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o  = st_q.bank;
    assign ptr_o   = st_q.ptr;
    assign base_o  = st_q.base;
    assign width_o = st_q.width;
    assign gap_o   = st_q.gap;
    assign lines_o = st_q.lines;
    assign done_o  = st_q.done;

    AST_SOF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st_q.ptr == $past(cfg_base) && !st_q.done)); // R2

    AST_STEP_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_adv && !frame_start && st_q.active && !st_q.done &&
         st_q.col != st_q.width - SPAN_W'(1))
        |=> st_q.ptr == $past(st_q.ptr) + PTR_W'(1)); // R3

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> st_q.ptr == end_ptr); // R6

    AST_HOLD_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !frame_start) |=> $stable(st_q.ptr)); // R7

    AST_BANK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.bank)); // R8
endmodule

// File: rtl/fbag_swap.sv
module fbag_swap
    import fbag_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic              swap_half,
    input  logic              swap_byte,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int unsigned NHW = DATA_W / HWORD_W;

    logic [DATA_W-1:0] half_stage;

    for (genvar i = 0; i < NHW; i++) begin : g_hw
        assign half_stage[i*HWORD_W +: HWORD_W] = swap_half
            ? din[(NHW-1-i)*HWORD_W +: HWORD_W]
            : din[i*HWORD_W +: HWORD_W];
        assign dout[i*HWORD_W +: HWORD_W] = swap_byte
            ? {half_stage[i*HWORD_W +: BYTE_W], half_stage[i*HWORD_W+BYTE_W +: BYTE_W]}
            : half_stage[i*HWORD_W +: HWORD_W];
    end
endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
    import fbag_pkg::*;
#(
    parameter int unsigned BANK_W = BANK_W_DEF,
    parameter int unsigned PTR_W  = PTR_W_DEF,
    parameter int unsigned SPAN_W = SPAN_W_DEF,
    parameter int unsigned LINE_W = LINE_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BANK_W-1:0]        cfg_bank,
    input  logic [PTR_W-1:0]         cfg_base,
    input  logic [SPAN_W-1:0]        cfg_width,
    input  logic [SPAN_W-1:0]        cfg_gap,
    input  logic [LINE_W-1:0]        cfg_lines_m1,
    input  logic                     frame_start,
    input  logic                     fetch_adv,
    input  logic                     swap_half,
    input  logic                     swap_byte,
    input  logic [DATA_W-1:0]        fetch_data_in,
    output logic [DATA_W-1:0]        fetch_data_out,
    output logic [BANK_W+PTR_W-1:0]  fetch_addr,
    output logic [PTR_W-1:0]         end_addr,
    output logic                     frame_done
);
    logic [BANK_W-1:0] bank_q;
    logic [PTR_W-1:0]  ptr_q, base_q;
    logic [SPAN_W-1:0] width_q, gap_q;
    logic [LINE_W-1:0] lines_q;

    fbag_walker #(
        .BANK_W(BANK_W), .PTR_W(PTR_W), .SPAN_W(SPAN_W), .LINE_W(LINE_W)
    ) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .fetch_adv    (fetch_adv),
        .cfg_bank     (cfg_bank),
        .cfg_base     (cfg_base),
        .cfg_width    (cfg_width),
        .cfg_gap      (cfg_gap),
        .cfg_lines_m1 (cfg_lines_m1),
        .end_ptr      (end_addr),
        .bank_o       (bank_q),
        .ptr_o        (ptr_q),
        .base_o       (base_q),
        .width_o      (width_q),
        .gap_o        (gap_q),
        .lines_o      (lines_q),
        .done_o       (frame_done)
    );

    fbag_endcalc #(
        .PTR_W(PTR_W), .SPAN_W(SPAN_W), .LINE_W(LINE_W)
    ) u_end (
        .base     (base_q),
        .width    (width_q),
        .gap      (gap_q),
        .lines_m1 (lines_q),
        .end_ptr  (end_addr)
    );

    fbag_swap #(.DATA_W(DATA_W)) u_swap (
        .swap_half (swap_half),
        .swap_byte (swap_byte),
        .din       (fetch_data_in),
        .dout      (fetch_data_out)
    );

    assign fetch_addr = {bank_q, ptr_q};
endmodule

// File: tb/fb_addr_gen_test.sv
module fb_addr_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSW = 6;
    // {data_in, swap_half, swap_byte, expected}
    localparam logic [65:0] SW_VEC [NSW] = '{
        {32'hA1B2C3D4, 1'b0, 1'b0, 32'hA1B2C3D4},
        {32'hA1B2C3D4, 1'b1, 1'b0, 32'hC3D4A1B2},
        {32'hA1B2C3D4, 1'b0, 1'b1, 32'hB2A1D4C3},
        {32'hA1B2C3D4, 1'b1, 1'b1, 32'hD4C3B2A1},
        {32'h00FF1234, 1'b1, 1'b1, 32'h3412FF00},
        {32'h00FF1234, 1'b0, 1'b1, 32'hFF003412}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [6:0]  cfg_bank;
    logic [20:0] cfg_base;
    logic [10:0] cfg_width, cfg_gap;
    logic [9:0]  cfg_lines_m1;
    logic frame_start, fetch_adv, swap_half, swap_byte;
    logic [31:0] fetch_data_in, fetch_data_out;
    logic [27:0] fetch_addr;
    logic [20:0] end_addr;
    logic frame_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fb_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_bank(cfg_bank), .cfg_base(cfg_base),
        .cfg_width(cfg_width), .cfg_gap(cfg_gap), .cfg_lines_m1(cfg_lines_m1),
        .frame_start(frame_start), .fetch_adv(fetch_adv),
        .swap_half(swap_half), .swap_byte(swap_byte),
        .fetch_data_in(fetch_data_in), .fetch_data_out(fetch_data_out),
        .fetch_addr(fetch_addr), .end_addr(end_addr), .frame_done(frame_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_frame(input logic [6:0] bk, input logic [20:0] bs,
                               input logic [10:0] w, input logic [10:0] g,
                               input logic [9:0] l, input logic with_adv);
        cfg_bank = bk; cfg_base = bs; cfg_width = w; cfg_gap = g; cfg_lines_m1 = l;
        frame_start = 1'b1; fetch_adv = with_adv;
        @(negedge clk);
        frame_start = 1'b0; fetch_adv = 1'b0;
    endtask

    task automatic adv_once();
        fetch_adv = 1'b1;
        @(negedge clk);
        fetch_adv = 1'b0;
    endtask

    task automatic walk_frame(input logic [6:0] bk, input logic [20:0] bs,
                              input logic [10:0] w, input logic [10:0] g,
                              input logic [9:0] l);
        logic [20:0] exp_end;
        exp_end = bs + 21'((32'(w) + 32'(g)) * (32'(l) + 1));
        start_frame(bk, bs, w, g, l, 1'b0);
        check("R2 reload", {4'h0, fetch_addr}, {4'h0, bk, bs});
        check("R2 done cleared", {31'h0, frame_done}, 32'h0);
        check("R5 end address", {11'h0, end_addr}, {11'h0, exp_end});
        for (int r = 0; r <= int'(l); r++) begin
            for (int c = 0; c < int'(w); c++) begin
                logic [20:0] ep;
                ep = bs + 21'(r * (int'(w) + int'(g)) + c);
                check("R3/R4/R8 walk address", {4'h0, fetch_addr}, {4'h0, bk, ep});
                adv_once();
            end
        end
        check("R6 done set", {31'h0, frame_done}, 32'h1);
        check("R6 pointer at end", {11'h0, fetch_addr[20:0]}, {11'h0, exp_end});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_bank = '0; cfg_base = '0; cfg_width = '0; cfg_gap = '0; cfg_lines_m1 = '0;
        frame_start = 1'b0; fetch_adv = 1'b0; swap_half = 1'b0; swap_byte = 1'b0;
        fetch_data_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 data reordering table
        for (int i = 0; i < NSW; i++) begin
            fetch_data_in = SW_VEC[i][65:34];
            swap_half     = SW_VEC[i][33];
            swap_byte     = SW_VEC[i][32];
            #1;
            check("R11 swap", fetch_data_out, SW_VEC[i][31:0]);
        end
        swap_half = 1'b0; swap_byte = 1'b0;

        // R1 reset state
        check("R1 addr", {4'h0, fetch_addr}, 32'h0);
        check("R1 end", {11'h0, end_addr}, 32'h0);
        check("R1 done", {31'h0, frame_done}, 32'h0);
        // R7 advance before any frame start
        cfg_base = 21'h123; adv_once(); adv_once();
        check("R7 idle ignores advance", {4'h0, fetch_addr}, 32'h0);

        // R3 R4 R5 R6 normal frames
        walk_frame(7'h12, 21'h000400, 11'd3, 11'd2, 10'd1);
        // R7 advance after done
        adv_once(); adv_once();
        check("R7 done ignores advance", {11'h0, fetch_addr[20:0]}, 32'h00040A);
        check("R7 done held", {31'h0, frame_done}, 32'h1);
        walk_frame(7'h01, 21'h010000, 11'd1, 11'd0, 10'd3);
        walk_frame(7'h7F, 21'h000000, 11'd5, 11'd7, 10'd2);

        // R8 wraparound of pointer; bank fixed
        walk_frame(7'h55, 21'h1FFFFE, 11'd4, 11'd1, 10'd0);
        check("R8 bank unchanged", {25'h0, fetch_addr[27:21]}, 32'h55);
        check("R8 wrapped end", {11'h0, end_addr}, 32'h3);

        // R9 mid-frame configuration change ignored
        start_frame(7'h03, 21'h000100, 11'd2, 11'd0, 10'd1, 1'b0);
        adv_once();
        cfg_bank = 7'h44; cfg_base = 21'h0ABCDE; cfg_width = 11'd9;
        cfg_gap = 11'd9; cfg_lines_m1 = 10'd9;
        adv_once();
        check("R9 addr unaffected", {4'h0, fetch_addr}, {4'h0, 7'h03, 21'h000102});
        check("R9 end unaffected", {11'h0, end_addr}, 32'h104);
        adv_once(); adv_once();
        check("R9 frame completes", {31'h0, frame_done}, 32'h1);

        // R10 reload beats same-cycle advance
        start_frame(7'h09, 21'h002000, 11'd4, 11'd4, 10'd4, 1'b1);
        check("R10 reload priority", {4'h0, fetch_addr}, {4'h0, 7'h09, 21'h002000});
        // R2 reload in mid frame restarts
        adv_once(); adv_once();
        start_frame(7'h09, 21'h003000, 11'd4, 11'd4, 10'd4, 1'b0);
        check("R2 mid-frame restart", {4'h0, fetch_addr}, {4'h0, 7'h09, 21'h003000});

        // R1 reset during activity
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears addr", {4'h0, fetch_addr}, 32'h0);
        check("R1 reset clears done", {31'h0, frame_done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule